// File: doc/BRIEF.md
# Encoder Position Counter with Selectable Reset and Debug-Halt Policies

This block keeps the shaft position for a quadrature encoder channel. Upstream logic has already turned the A/B edges into a count strobe and a direction bit. On each enabled strobe the counter steps up or down by one. It stays between zero and a programmable maximum, and it wraps at either end. A wrap produces a one-cycle overflow or underflow pulse. An index strobe and a unit-time strobe can also clear or reload the count. A 2-bit reset-source field chooses which of these strobes acts.

A second 2-bit field sets what happens while a debug-halt input is high. The counter can freeze at once, run on until its next wrap and then freeze, or ignore the halt. A sticky flag reports whether an index strobe has been seen since the counter was last enabled. The one-shot reset source uses this same flag to arm itself only once.

Both fields are held in internal configuration registers. A write strobe loads them, and they return to zero on reset.

Top module: `enc_pos_counter`

## Requirements
- R1: After reset the position is 0, both wrap pulses are low, the first-index flag is low, and both configuration fields hold 0. The block therefore starts in every-index reset with immediate halt.
- R2: While `enable` is high and nothing takes priority, each `cntStrobe` moves the position by one: up when `dirUp`=1, down when `dirUp`=0. The result is visible after the next rising clock edge. While `enable` is low the position is forced to 0.
- R3: A count up from a position at or above `maxPos` gives 0 and raises `ovfPulse` for exactly one cycle. A count down from 0 gives `maxPos` and raises `unfPulse` for exactly one cycle. The two pulses are never high together.
- R4: With reset source 0, every index strobe loads the position. It loads 0 when `dirUp`=1 and `maxPos` when `dirUp`=0.
- R5: With reset source 1, index and unit-time strobes leave the position untouched, and the count only wraps at `maxPos` and 0.
- R6: With reset source 2, the first index strobe after enable loads the position as in R4. Later index strobes leave it untouched until `enable` is dropped and raised again.
- R7: With reset source 3, each unit-time strobe loads 0 and index strobes leave the position untouched.
- R8: When a load from R4, R6 or R7 falls in the same cycle as a count strobe, the load wins, the count is lost, and no wrap pulse is raised.
- R9: With halt policy 0, from the first cycle that `dbgHalt` is high the position and the first-index flag hold, and all strobes in those cycles are dropped.
- R10: With halt policy 1, counting goes on while `dbgHalt` is high until one wrap has happened; that wrap is applied. After it the position and flag hold until `dbgHalt` goes low.
- R11: With halt policy 2 or 3, `dbgHalt` has no effect.
- R12: `firstIdxSeen` is set by any index strobe taken while enabled and not halted, whatever the reset source. It is cleared only by reset or by `enable` low.
- R13: A cycle with `cfgWr`=1 loads `cfgRstMode` and `cfgHaltMode`. The new values govern the cycles that follow, not the write cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Counter enable; low clears position and flag |
| cntStrobe | input | 1 | One decoded count step |
| dirUp | input | 1 | 1 = count up, 0 = count down; also picks the index load value |
| indexEvt | input | 1 | Index event strobe |
| unitEvt | input | 1 | Unit-time event strobe |
| dbgHalt | input | 1 | Debug halt request |
| cfgWr | input | 1 | Loads both configuration fields |
| cfgRstMode | input | 2 | Reset source: 0 every index, 1 wrap only, 2 first index, 3 unit time |
| cfgHaltMode | input | 2 | Halt policy: 0 immediate, 1 after next wrap, 2/3 ignore |
| maxPos | input | W | Highest position value |
| position | output | W | Current count |
| ovfPulse | output | 1 | One-cycle pulse on an upward wrap |
| unfPulse | output | 1 | One-cycle pulse on a downward wrap |
| firstIdxSeen | output | 1 | Sticky first-index flag |

## Verification
All state is one cycle from the ports. A wrong count, a wrong load choice or a mishandled priority shows in `position` or in a wrap pulse right after the clock edge that used the stimulus. A wrong hidden state is slower to show. A halt-park bit that is set or cleared at the wrong time, or a stale first-index flag, appears only on a later strobe, when the block moves where it should hold or holds where it should move. For that reason the stimulus keeps halt and index activity going across many wraps under every mode pair.

// File: rtl/pos_pkg.sv
package pos_pkg;

  typedef enum logic [1:0] {
    RST_EVERY_INDEX = 2'd0,
    RST_WRAP_ONLY   = 2'd1,
    RST_FIRST_INDEX = 2'd2,
    RST_UNIT_TIME   = 2'd3
  } rstMode_e;

  typedef enum logic [1:0] {
    HALT_NOW     = 2'd0,
    HALT_AT_WRAP = 2'd1,
    HALT_IGNORE  = 2'd2,
    HALT_IGNORE2 = 2'd3
  } haltMode_e;

  // strobes from control to datapath, at most one of load/step set
  typedef struct packed {
    logic clear;
    logic loadZero;
    logic loadMax;
    logic stepUp;
    logic stepDown;
  } posCmd_t;

endpackage

// File: rtl/pos_ctrl.sv
module pos_ctrl
  import pos_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      cntStrobe,
  input  logic      dirUp,
  input  logic      indexEvt,
  input  logic      unitEvt,
  input  logic      dbgHalt,
  input  logic      cfgWr,
  input  logic [1:0] cfgRstMode,
  input  logic [1:0] cfgHaltMode,
  input  logic      atMax,
  input  logic      atZero,
  output posCmd_t   cmd,
  output logic      firstIdxSeen,
  output rstMode_e  rstModeQ,
  output haltMode_e haltModeQ
);

  logic parkQ;
  logic firstQ;
  logic halted;
  logic live;
  logic idxHit;
  logic unitHit;
  logic wrapNow;

  // halt decision for this cycle
  always_comb begin
    unique case (haltModeQ)
      HALT_NOW:     halted = dbgHalt;
      HALT_AT_WRAP: halted = dbgHalt && parkQ;
      default:      halted = 1'b0;
    endcase
    live = enable && !halted;
  end

  // reset-source selection
  always_comb begin
    unique case (rstModeQ)
      RST_EVERY_INDEX: begin idxHit = indexEvt;            unitHit = 1'b0;    end
      RST_FIRST_INDEX: begin idxHit = indexEvt && !firstQ; unitHit = 1'b0;    end
      RST_UNIT_TIME:   begin idxHit = 1'b0;                unitHit = unitEvt; end
      default:         begin idxHit = 1'b0;                unitHit = 1'b0;    end
    endcase
  end

  // command build: load beats count
  always_comb begin
    cmd       = '0;
    cmd.clear = !enable;
    if (live) begin
      if (idxHit) begin
        cmd.loadZero = dirUp;
        cmd.loadMax  = !dirUp;
      end else if (unitHit) begin
        cmd.loadZero = 1'b1;
      end else if (cntStrobe) begin
        cmd.stepUp   = dirUp;
        cmd.stepDown = !dirUp;
      end
    end
    wrapNow = (cmd.stepUp && atMax) || (cmd.stepDown && atZero);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parkQ     <= 1'b0;
      firstQ    <= 1'b0;
      rstModeQ  <= RST_EVERY_INDEX;
      haltModeQ <= HALT_NOW;
    end else begin
      parkQ <= enable && dbgHalt &&
               (parkQ || ((haltModeQ == HALT_AT_WRAP) && wrapNow));
      if (!enable)
        firstQ <= 1'b0;
      else if (live && indexEvt)
        firstQ <= 1'b1;
      if (cfgWr) begin
        rstModeQ  <= rstMode_e'(cfgRstMode);
        haltModeQ <= haltMode_e'(cfgHaltMode);
      end
    end
  end

  assign firstIdxSeen = firstQ;

endmodule

// File: rtl/pos_datapath.sv
module pos_datapath
  import pos_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  posCmd_t      cmd,
  input  logic [W-1:0] maxPos,
  output logic [W-1:0] position,
  output logic         ovfPulse,
  output logic         unfPulse,
  output logic         atMax,
  output logic         atZero
);

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  assign atMax  = (position >= maxPos);
  assign atZero = (position == ZERO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      position <= ZERO;
      ovfPulse <= 1'b0;
      unfPulse <= 1'b0;
    end else begin
      ovfPulse <= 1'b0;
      unfPulse <= 1'b0;
      if (cmd.clear || cmd.loadZero) begin
        position <= ZERO;
      end else if (cmd.loadMax) begin
        position <= maxPos;
      end else if (cmd.stepUp) begin
        if (atMax) begin
          position <= ZERO;
          ovfPulse <= 1'b1;
        end else begin
          position <= position + ONE;
        end
      end else if (cmd.stepDown) begin
        if (atZero) begin
          position <= maxPos;
          unfPulse <= 1'b1;
        end else begin
          position <= position - ONE;
        end
      end
    end
  end

endmodule

// File: rtl/enc_pos_counter.sv
module enc_pos_counter
  import pos_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         cntStrobe,
  input  logic         dirUp,
  input  logic         indexEvt,
  input  logic         unitEvt,
  input  logic         dbgHalt,
  input  logic         cfgWr,
  input  logic [1:0]   cfgRstMode,
  input  logic [1:0]   cfgHaltMode,
  input  logic [W-1:0] maxPos,
  output logic [W-1:0] position,
  output logic         ovfPulse,
  output logic         unfPulse,
  output logic         firstIdxSeen
);

  posCmd_t   cmd;
  logic      atMax;
  logic      atZero;
  rstMode_e  rstModeQ;
  haltMode_e haltModeQ;

  pos_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cntStrobe(cntStrobe),
    .dirUp(dirUp), .indexEvt(indexEvt), .unitEvt(unitEvt), .dbgHalt(dbgHalt),
    .cfgWr(cfgWr), .cfgRstMode(cfgRstMode), .cfgHaltMode(cfgHaltMode),
    .atMax(atMax), .atZero(atZero), .cmd(cmd), .firstIdxSeen(firstIdxSeen),
    .rstModeQ(rstModeQ), .haltModeQ(haltModeQ)
  );

  pos_datapath #(.W(W)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .maxPos(maxPos),
    .position(position), .ovfPulse(ovfPulse), .unfPulse(unfPulse),
    .atMax(atMax), .atZero(atZero)
  );

endmodule

// File: rtl/enc_pos_checker.sv
module enc_pos_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         enable,
  input logic         cntStrobe,
  input logic         dirUp,
  input logic         indexEvt,
  input logic         dbgHalt,
  input logic [W-1:0] maxPos,
  input logic [W-1:0] position,
  input logic         ovfPulse,
  input logic         unfPulse,
  input logic         firstIdxSeen,
  input logic [1:0]   rstModeQ,
  input logic [1:0]   haltModeQ
);

  a_r3_pulse_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfPulse && unfPulse));

  a_r3_ovf_zero: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (position == '0));

  a_r3_ovf_cause: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> $past(enable && cntStrobe && dirUp));

  a_r3_unf_max: assert property (@(posedge clk) disable iff (!rstN)
    unfPulse |-> (position == $past(maxPos)));

  a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (position == '0 && !firstIdxSeen));

  a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rstN)
    (enable && dbgHalt && haltModeQ == 2'd0)
      |=> (position == $past(position) && firstIdxSeen == $past(firstIdxSeen)));

  a_r4_index_load: assert property (@(posedge clk) disable iff (!rstN)
    (enable && indexEvt && dirUp && rstModeQ == 2'd0 && haltModeQ[1])
      |=> (position == '0));

  a_r8_load_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (enable && indexEvt && rstModeQ == 2'd0 && haltModeQ[1])
      |=> (!ovfPulse && !unfPulse));

  a_r12_flag_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(firstIdxSeen) |-> $past(indexEvt && enable));

endmodule

bind enc_pos_counter enc_pos_checker #(.W(W)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .cntStrobe(cntStrobe),
  .dirUp(dirUp), .indexEvt(indexEvt), .dbgHalt(dbgHalt), .maxPos(maxPos),
  .position(position), .ovfPulse(ovfPulse), .unfPulse(unfPulse),
  .firstIdxSeen(firstIdxSeen), .rstModeQ(rstModeQ), .haltModeQ(haltModeQ)
);

// File: tb/tb_enc_pos_counter.sv
module tb_enc_pos_counter;

  localparam int W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rstN = 1'b0;
  logic         en = 1'b0, cs = 1'b0, up = 1'b1, idx = 1'b0, ue = 1'b0, dh = 1'b0;
  logic         cw = 1'b0;
  logic [1:0]   crm = 2'd0, chm = 2'd0;
  logic [W-1:0] mx = W'(9);
  logic [W-1:0] position;
  logic         ovfPulse, unfPulse, firstIdxSeen;

  enc_pos_counter #(.W(W)) dut (
    .clk(clk), .rstN(rstN), .enable(en), .cntStrobe(cs), .dirUp(up),
    .indexEvt(idx), .unitEvt(ue), .dbgHalt(dh), .cfgWr(cw),
    .cfgRstMode(crm), .cfgHaltMode(chm), .maxPos(mx),
    .position(position), .ovfPulse(ovfPulse), .unfPulse(unfPulse),
    .firstIdxSeen(firstIdxSeen)
  );

  int checks = 0;
  int errors = 0;

  // reference state
  logic [W-1:0] mPos = '0;
  logic mFlag = 0, mPark = 0, mOvf = 0, mUnf = 0;
  logic [1:0] mRm = 0, mHm = 0;

  function automatic logic isHalted();
    return dh && (mHm == 2'd0 || (mHm == 2'd1 && mPark));
  endfunction

  task automatic modelStep();
    logic halted, wrap;
    halted = isHalted();
    wrap = 1'b0;
    mOvf = 1'b0; mUnf = 1'b0;
    if (!en) begin
      mPos = '0; mFlag = 1'b0; mPark = 1'b0;
    end else begin
      if (!halted) begin
        if (idx && (mRm == 2'd0 || (mRm == 2'd2 && !mFlag)))
          mPos = up ? '0 : mx;
        else if (ue && mRm == 2'd3)
          mPos = '0;
        else if (cs && up) begin
          if (mPos >= mx) begin mPos = '0; mOvf = 1'b1; wrap = 1'b1; end
          else mPos = mPos + 1'b1;
        end else if (cs) begin
          if (mPos == '0) begin mPos = mx; mUnf = 1'b1; wrap = 1'b1; end
          else mPos = mPos - 1'b1;
        end
        if (idx) mFlag = 1'b1;
      end
      mPark = dh && (mPark || (mHm == 2'd1 && wrap));
    end
    if (cw) begin mRm = crm; mHm = chm; end
  endtask

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check(tag, "position", position, mPos);
    check(tag, "ovfPulse", W'(ovfPulse), W'(mOvf));
    check(tag, "unfPulse", W'(unfPulse), W'(mUnf));
    check(tag, "firstIdxSeen", W'(firstIdxSeen), W'(mFlag));
  endtask

  // one clock: inputs already set at negedge
  task automatic tick(input string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    checkAll(tag);
    cs = 0; idx = 0; ue = 0; cw = 0;
  endtask

  task automatic setCfg(input logic [1:0] r, input logic [1:0] h, input string tag);
    cw = 1; crm = r; chm = h;
    tick(tag);
  endtask

  function automatic string rndTag();
    if (!en) return "R2";
    if (dh && mHm == 2'd0) return "R9";
    if (dh && mHm == 2'd1) return "R10";
    if (dh) return "R11";
    if (idx && mRm == 2'd0) return "R4";
    if (idx && mRm == 2'd2) return "R6";
    if (ue && mRm == 2'd3) return "R7";
    if ((idx || ue) && mRm == 2'd1) return "R5";
    return "R3";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while and after reset
    checkAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // R1 default modes act as every-index and immediate halt; R2 counting
    en = 1; tick("R2");
    for (int i = 0; i < 3; i++) begin cs = 1; up = 1; tick("R2"); end
    idx = 1; up = 1; tick("R1");
    cs = 1; dh = 1; tick("R1");
    dh = 0;

    // R3: wrap up and down
    for (int i = 0; i < 10; i++) begin cs = 1; up = 1; tick("R3"); end
    tick("R3");
    cs = 1; up = 0; tick("R3");
    tick("R3");
    cs = 1; up = 0; tick("R2");

    // R4 down-direction load, R8 priority
    idx = 1; up = 0; tick("R4");
    idx = 1; cs = 1; up = 1; tick("R8");

    // R13 config write; R6 first-index; R12 flag
    setCfg(2'd2, 2'd2, "R13");
    en = 0; tick("R12");
    en = 1; for (int i = 0; i < 4; i++) begin cs = 1; up = 1; tick("R2"); end
    idx = 1; up = 0; tick("R6");
    cs = 1; up = 0; tick("R6");
    idx = 1; up = 1; tick("R6");
    en = 0; tick("R12");
    en = 1; cs = 1; up = 1; tick("R2");
    idx = 1; up = 1; tick("R6");

    // R5 wrap only
    setCfg(2'd1, 2'd2, "R13");
    cs = 1; up = 1; tick("R5");
    idx = 1; tick("R5");
    ue = 1; tick("R5");

    // R7 unit time
    setCfg(2'd3, 2'd2, "R13");
    cs = 1; up = 1; tick("R7");
    idx = 1; up = 0; tick("R7");
    ue = 1; cs = 1; up = 1; tick("R8");

    // R10 run to wrap then hold
    setCfg(2'd1, 2'd1, "R13");
    for (int i = 0; i < 7; i++) begin cs = 1; up = 1; tick("R10"); end
    dh = 1;
    for (int i = 0; i < 6; i++) begin cs = 1; up = 1; tick("R10"); end
    dh = 0; cs = 1; up = 1; tick("R10");

    // R11 ignore halt
    setCfg(2'd0, 2'd3, "R13");
    dh = 1;
    for (int i = 0; i < 12; i++) begin cs = 1; up = 0; tick("R11"); end
    idx = 1; up = 1; tick("R11");
    dh = 0;

    // R9 halt drops index and holds flag
    en = 0; tick("R2");
    en = 1; setCfg(2'd0, 2'd0, "R13");
    dh = 1; idx = 1; cs = 1; tick("R9");
    dh = 0;

    // random phases over all mode pairs
    void'($urandom(32'h5eed_0042));
    for (int m = 0; m < 16; m++) begin
      cw = 1; crm = 2'(m >> 2); chm = 2'(m);
      mx = W'($urandom_range(2, 12));
      tick("R13");
      for (int c = 0; c < 300; c++) begin
        en  = ($urandom_range(0, 99) > 2);
        cs  = ($urandom_range(0, 99) < 60);
        up  = ($urandom_range(0, 99) < 55);
        idx = ($urandom_range(0, 99) < 8);
        ue  = ($urandom_range(0, 99) < 6);
        if ($urandom_range(0, 99) < 10) dh = ~dh;
        if ($urandom_range(0, 99) < 2) mx = W'($urandom_range(2, 12));
        tick(rndTag());
      end
      dh = 0;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule